// File: doc/BRIEF.md
# Audio Sample FIFO with Level-Threshold Requests

This block buffers audio samples for one direction of a serial audio port. It stores up to eight 32-bit words and keeps a count of how many it holds. The count is compared against programmable depths to drive three request lines: one interrupt line and two independent DMA lines. Words are pushed through a write port and taken from a read port. The read port is show-ahead: the oldest word is always visible while the FIFO is not empty. A synchronous clear empties the FIFO in one cycle.

The direction is fixed by the parameter `IS_RX`, and it sets the sense of every comparison:

- **Receive instance:** asks to be drained once the count has climbed to a depth.
- **Transmit instance:** asks to be refilled once the count has dropped to a depth.

The two DMA lines take 5-bit depths. The interrupt line takes a 4-bit depth. Each line has its own enable. The three request states are also gathered into a 3-bit status word.

Fill tracking is a three-state machine:

- **States:** `ST_EMPTY` (nothing stored), `ST_PART` (between one word and one short of full) and `ST_FULL` (all entries used).
- **Transitions:** `ST_EMPTY` to `ST_PART` on an accepted write. `ST_PART` to `ST_FULL` on a write without a read at one short of full. `ST_PART` to `ST_EMPTY` on a read without a write at one word. `ST_FULL` to `ST_PART` on an accepted read. Any state goes to `ST_EMPTY` on clear.

Top module: `audio_fifo_req`

## Requirements
- R1: After reset, `empty` is 1, `full` is 0 and `level` is 0.
- R2: Words leave in the order they were accepted, and `rd_data` shows the oldest stored word whenever `empty` is 0.
- R3: `level` rises by one after a cycle with only an accepted write, falls by one after a cycle with only an accepted read, and is unchanged after a cycle with both.
- R4: With 8 words stored, `full` is 1 and `level` is 8. A write while full is dropped: `level` stays 8 and the dropped word is never read out.
- R5: A read while empty is ignored and `level` stays 0. A write and read together while empty stores the word, giving `level` 1. A write and read together while full removes one word and drops the write, giving `level` 7.
- R6: `clr` high at a clock edge leaves `level` 0 and `empty` 1 after that edge, and it overrides a write or read in the same cycle.
- R7: In a receive instance (`IS_RX`=1), each request is high exactly when its enable is 1 and `level` >= its depth.
- R8: In a transmit instance (`IS_RX`=0), each request is high exactly when its enable is 1 and `level` <= its depth.
- R9: The interrupt depth is 4 bits wide and each DMA depth is 5 bits wide. The three lines use independent depths and enables. Requests follow `level` in the same cycle it changes.
- R10: `req_status` bit 0 equals `irq_req`, bit 1 equals `dma_a_req` and bit 2 equals `dma_b_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of contents and level |
| wr_en | input | 1 | Push request |
| wr_data | input | 32 | Word to push |
| full | output | 1 | All entries used |
| rd_en | input | 1 | Pop request |
| rd_data | output | 32 | Oldest stored word (show-ahead) |
| empty | output | 1 | No entries stored |
| level | output | 5 | Number of stored words |
| irq_en | input | 1 | Interrupt line enable |
| irq_depth | input | 4 | Interrupt threshold |
| dma_a_en | input | 1 | First DMA line enable |
| dma_a_depth | input | 5 | First DMA line threshold |
| dma_b_en | input | 1 | Second DMA line enable |
| dma_b_depth | input | 5 | Second DMA line threshold |
| irq_req | output | 1 | Interrupt request |
| dma_a_req | output | 1 | First DMA request |
| dma_b_req | output | 1 | Second DMA request |
| req_status | output | 3 | {dma_b_req, dma_a_req, irq_req} |

## Verification
A push and a pop can arrive in the same cycle, and a clear can coincide with either of them. The bench drives simultaneous push and pop three times: from the empty state, from a partial fill and from the full state. It then judges the resulting level and the word now at the head against the rules in R3 and R5. It also raises a clear together with a push and confirms the FIFO ends empty. Both a receive and a transmit instance see the same stimulus, so each request comparison is checked at every level from 0 to 8.

// File: rtl/audio_fifo_req_pkg.sv
package audio_fifo_req_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_PART  = 2'd1,
        ST_FULL  = 2'd2
    } fill_state_t;

endpackage

// File: rtl/audio_fifo_req_ctrl.sv
module audio_fifo_req_ctrl
    import audio_fifo_req_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int LVL_W = 5,
    parameter int PTR_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_en,
    input  logic             rd_en,
    output logic             wr_ok,
    output logic             rd_ok,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [LVL_W-1:0] level,
    output logic             empty,
    output logic             full
);

    localparam logic [LVL_W-1:0] LVL_TOP  = LVL_W'(DEPTH);
    localparam logic [LVL_W-1:0] LVL_LAST = LVL_W'(DEPTH - 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    fill_state_t state_q, state_d;

    // acceptance of each side
    always_comb begin
        wr_ok = wr_en && !clr && (state_q != ST_FULL);
        rd_ok = rd_en && !clr && (state_q != ST_EMPTY);
    end

    // next-state decision
    always_comb begin
        state_d = state_q;
        if (clr) begin
            state_d = ST_EMPTY;
        end else begin
            unique case (state_q)
                ST_EMPTY: if (wr_ok) state_d = ST_PART;
                ST_PART: begin
                    if (wr_ok && !rd_ok && level == LVL_LAST)
                        state_d = ST_FULL;
                    else if (rd_ok && !wr_ok && level == LVL_W'(1))
                        state_d = ST_EMPTY;
                end
                ST_FULL:  if (rd_ok) state_d = ST_PART;
                default:  state_d = ST_EMPTY;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // outputs decoded from state
    always_comb begin
        empty = 1'b0;
        full  = 1'b0;
        unique case (state_q)
            ST_EMPTY: empty = 1'b1;
            ST_PART:  ;
            ST_FULL:  full  = 1'b1;
            default:  empty = 1'b1;
        endcase
    end

    // level and pointers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level  <= '0;
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else if (clr) begin
            level  <= '0;
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_ok && !rd_ok && level != LVL_TOP)
                level <= level + LVL_W'(1);
            else if (rd_ok && !wr_ok && level != '0)
                level <= level - LVL_W'(1);
            if (wr_ok)
                wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + PTR_W'(1);
            if (rd_ok)
                rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + PTR_W'(1);
        end
    end

endmodule

// File: rtl/audio_fifo_req_store.sv
module audio_fifo_req_store #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 32,
    parameter int PTR_W  = 3
) (
    input  logic              clk,
    input  logic              wr_ok,
    input  logic [PTR_W-1:0]  wr_ptr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_ptr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wr_ptr] <= wr_data;
    end

    assign rd_data = mem[rd_ptr];

endmodule

// File: rtl/audio_fifo_req_cmp.sv
module audio_fifo_req_cmp #(
    parameter int LVL_W = 5,
    parameter int THR_W = 5,
    parameter bit IS_RX = 1'b1
) (
    input  logic             en,
    input  logic [THR_W-1:0] thr,
    input  logic [LVL_W-1:0] level,
    output logic             req
);

    localparam int CMP_W = (LVL_W > THR_W) ? LVL_W : THR_W;

    logic [CMP_W-1:0] lvl_x, thr_x;

    assign lvl_x = CMP_W'(level);
    assign thr_x = CMP_W'(thr);

    generate
        if (IS_RX) begin : g_rx
            assign req = en && (lvl_x >= thr_x);
        end else begin : g_tx
            assign req = en && (lvl_x <= thr_x);
        end
    endgenerate

endmodule

// File: rtl/audio_fifo_req.sv
module audio_fifo_req
    import audio_fifo_req_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 32,
    parameter int LVL_W  = 5,
    parameter int DMA_DW = 5,
    parameter int IRQ_DW = 4,
    parameter bit IS_RX  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              full,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty,
    output logic [LVL_W-1:0]  level,
    input  logic              irq_en,
    input  logic [IRQ_DW-1:0] irq_depth,
    input  logic              dma_a_en,
    input  logic [DMA_DW-1:0] dma_a_depth,
    input  logic              dma_b_en,
    input  logic [DMA_DW-1:0] dma_b_depth,
    output logic              irq_req,
    output logic              dma_a_req,
    output logic              dma_b_req,
    output logic [2:0]        req_status
);

    localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int NUM_DMA = 2;

    logic             wr_ok, rd_ok;
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    audio_fifo_req_ctrl #(.DEPTH(DEPTH), .LVL_W(LVL_W), .PTR_W(PTR_W)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .wr_ok  (wr_ok),
        .rd_ok  (rd_ok),
        .wr_ptr (wr_ptr),
        .rd_ptr (rd_ptr),
        .level  (level),
        .empty  (empty),
        .full   (full)
    );

    audio_fifo_req_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .PTR_W(PTR_W)) u_store (
        .clk     (clk),
        .wr_ok   (wr_ok),
        .wr_ptr  (wr_ptr),
        .wr_data (wr_data),
        .rd_ptr  (rd_ptr),
        .rd_data (rd_data)
    );

    audio_fifo_req_cmp #(.LVL_W(LVL_W), .THR_W(IRQ_DW), .IS_RX(IS_RX)) u_irq_cmp (
        .en    (irq_en),
        .thr   (irq_depth),
        .level (level),
        .req   (irq_req)
    );

    logic [NUM_DMA-1:0]              dma_en_v;
    logic [NUM_DMA-1:0][DMA_DW-1:0]  dma_thr_v;
    logic [NUM_DMA-1:0]              dma_req_v;

    assign dma_en_v  = {dma_b_en, dma_a_en};
    assign dma_thr_v = {dma_b_depth, dma_a_depth};

    generate
        for (genvar gi = 0; gi < NUM_DMA; gi++) begin : g_dma
            audio_fifo_req_cmp #(.LVL_W(LVL_W), .THR_W(DMA_DW), .IS_RX(IS_RX)) u_dma_cmp (
                .en    (dma_en_v[gi]),
                .thr   (dma_thr_v[gi]),
                .level (level),
                .req   (dma_req_v[gi])
            );
        end
    endgenerate

    assign dma_a_req  = dma_req_v[0];
    assign dma_b_req  = dma_req_v[1];
    assign req_status = {dma_b_req, dma_a_req, irq_req};

endmodule

// File: rtl/audio_fifo_req_chk.sv
module audio_fifo_req_chk #(
    parameter int DEPTH  = 8,
    parameter int LVL_W  = 5,
    parameter int DMA_DW = 5,
    parameter int IRQ_DW = 4,
    parameter bit IS_RX  = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr,
    input logic              wr_en,
    input logic              rd_en,
    input logic              full,
    input logic              empty,
    input logic [LVL_W-1:0]  level,
    input logic              irq_en,
    input logic [IRQ_DW-1:0] irq_depth,
    input logic              dma_a_en,
    input logic [DMA_DW-1:0] dma_a_depth,
    input logic              irq_req,
    input logic              dma_a_req
);

    localparam logic [LVL_W-1:0] LVL_TOP = LVL_W'(DEPTH);

    // R1
    empty_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty == (level == '0));

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level <= LVL_TOP) && (full == (level == LVL_TOP)));

    // R3
    level_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (level == $past(level) || level == $past(level) + LVL_W'(1)
                  || level == $past(level) - LVL_W'(1)));

    // R4
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en && !clr) |=> (level == LVL_TOP));

    // R5
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_en && !wr_en && !clr) |=> (level == '0));

    // R6
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (level == '0 && empty));

    generate
        if (IS_RX) begin : g_rx_chk
            // R7
            rx_irq_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
                irq_req == (irq_en && (32'(level) >= 32'(irq_depth))));
            // R7
            rx_dma_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
                dma_a_req == (dma_a_en && (32'(level) >= 32'(dma_a_depth))));
        end else begin : g_tx_chk
            // R8
            tx_irq_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
                irq_req == (irq_en && (32'(level) <= 32'(irq_depth))));
            // R8
            tx_dma_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
                dma_a_req == (dma_a_en && (32'(level) <= 32'(dma_a_depth))));
        end
    endgenerate

endmodule

bind audio_fifo_req audio_fifo_req_chk #(
    .DEPTH(DEPTH), .LVL_W(LVL_W), .DMA_DW(DMA_DW), .IRQ_DW(IRQ_DW), .IS_RX(IS_RX)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (clr),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .full        (full),
    .empty       (empty),
    .level       (level),
    .irq_en      (irq_en),
    .irq_depth   (irq_depth),
    .dma_a_en    (dma_a_en),
    .dma_a_depth (dma_a_depth),
    .irq_req     (irq_req),
    .dma_a_req   (dma_a_req)
);

// File: tb/test_audio_fifo_req.sv
`timescale 1ns/1ps
module test_audio_fifo_req;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic        irq_en = 1'b0;
    logic [3:0]  irq_depth = '0;
    logic        dma_a_en = 1'b0;
    logic [4:0]  dma_a_depth = '0;
    logic        dma_b_en = 1'b0;
    logic [4:0]  dma_b_depth = '0;

    logic        full, empty, full_t, empty_t;
    logic [31:0] rd_data, rd_data_t;
    logic [4:0]  level, level_t;
    logic        irq_req, dma_a_req, dma_b_req;
    logic        irq_req_t, dma_a_req_t, dma_b_req_t;
    logic [2:0]  req_status, req_status_t;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    audio_fifo_req #(.IS_RX(1'b1)) i_audio_fifo_req (
        .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en), .wr_data(wr_data),
        .full(full), .rd_en(rd_en), .rd_data(rd_data), .empty(empty), .level(level),
        .irq_en(irq_en), .irq_depth(irq_depth), .dma_a_en(dma_a_en),
        .dma_a_depth(dma_a_depth), .dma_b_en(dma_b_en), .dma_b_depth(dma_b_depth),
        .irq_req(irq_req), .dma_a_req(dma_a_req), .dma_b_req(dma_b_req),
        .req_status(req_status)
    );

    audio_fifo_req #(.IS_RX(1'b0)) i_audio_fifo_req_tx (
        .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en), .wr_data(wr_data),
        .full(full_t), .rd_en(rd_en), .rd_data(rd_data_t), .empty(empty_t), .level(level_t),
        .irq_en(irq_en), .irq_depth(irq_depth), .dma_a_en(dma_a_en),
        .dma_a_depth(dma_a_depth), .dma_b_en(dma_b_en), .dma_b_depth(dma_b_depth),
        .irq_req(irq_req_t), .dma_a_req(dma_a_req_t), .dma_b_req(dma_b_req_t),
        .req_status(req_status_t)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // one clock with the given inputs; sample 1 ns after the edge
    task automatic cyc(input logic w, input logic [31:0] d, input logic r, input logic c);
        wr_en = w; wr_data = d; rd_en = r; clr = c;
        @(posedge clk); #1;
        wr_en = 1'b0; rd_en = 1'b0; clr = 1'b0;
    endtask

    task automatic t_reset();
        check("R1", "empty", 32'(empty), 1);
        check("R1", "full", 32'(full), 0);
        check("R1", "level", 32'(level), 0);
        check("R1", "tx level", 32'(level_t), 0);
    endtask

    task automatic t_order();
        cyc(1, 32'hA000_0001, 0, 0);
        check("R3", "level after push", 32'(level), 1);
        cyc(1, 32'hA000_0002, 0, 0);
        cyc(1, 32'hA000_0003, 0, 0);
        check("R3", "level after 3 pushes", 32'(level), 3);
        for (int i = 1; i <= 3; i++) begin
            check("R2", "head word", rd_data, 32'hA000_0000 + 32'(i));
            cyc(0, 0, 1, 0);
            check("R3", "level after pop", 32'(level), 32'(3 - i));
        end
        check("R2", "empty after drain", 32'(empty), 1);
    endtask

    task automatic t_overflow();
        for (int i = 0; i < 8; i++) cyc(1, 32'hB000_0000 + 32'(i), 0, 0);
        check("R4", "full", 32'(full), 1);
        check("R4", "level full", 32'(level), 8);
        cyc(1, 32'hDEAD_BEEF, 0, 0);
        check("R4", "level after dropped write", 32'(level), 8);
        for (int i = 0; i < 8; i++) begin
            check("R4", "stored word", rd_data, 32'hB000_0000 + 32'(i));
            cyc(0, 0, 1, 0);
        end
        check("R4", "level after drain", 32'(level), 0);
        cyc(0, 0, 1, 0);
        check("R5", "level after read while empty", 32'(level), 0);
        check("R5", "empty after read while empty", 32'(empty), 1);
    endtask

    task automatic t_simultaneous();
        cyc(1, 32'hC000_0001, 1, 0);
        check("R5", "push+pop from empty level", 32'(level), 1);
        check("R5", "push+pop from empty head", rd_data, 32'hC000_0001);
        cyc(1, 32'hC000_0002, 1, 0);
        check("R3", "push+pop partial level", 32'(level), 1);
        check("R3", "push+pop partial head", rd_data, 32'hC000_0002);
        for (int i = 3; i <= 9; i++) cyc(1, 32'hC000_0000 + 32'(i), 0, 0);
        check("R4", "refilled level", 32'(level), 8);
        cyc(1, 32'hEEEE_EEEE, 1, 0);
        check("R5", "push+pop from full level", 32'(level), 7);
        check("R5", "push+pop from full head", rd_data, 32'hC000_0003);
        check("R5", "not full after", 32'(full), 0);
    endtask

    task automatic t_clear();
        cyc(1, 32'hF000_0000, 1, 1);
        check("R6", "level after clear with push", 32'(level), 0);
        check("R6", "empty after clear", 32'(empty), 1);
        cyc(1, 32'h1234_5678, 0, 0);
        check("R6", "head after clear and push", rd_data, 32'h1234_5678);
        cyc(0, 0, 0, 1);
        check("R6", "level after plain clear", 32'(level), 0);
    endtask

    task automatic t_thresholds();
        logic ex_irq, ex_a, ex_b;
        irq_en = 1; irq_depth = 4'd6;
        dma_a_en = 1; dma_a_depth = 5'd4;
        dma_b_en = 1; dma_b_depth = 5'd2;
        for (int l = 0; l <= 8; l++) begin
            #1;
            check("R9", "level", 32'(level), 32'(l));
            ex_irq = (l >= 6); ex_a = (l >= 4); ex_b = (l >= 2);
            check("R7", "rx irq", 32'(irq_req), 32'(ex_irq));
            check("R7", "rx dma a", 32'(dma_a_req), 32'(ex_a));
            check("R7", "rx dma b", 32'(dma_b_req), 32'(ex_b));
            check("R10", "rx status", 32'(req_status), 32'({ex_b, ex_a, ex_irq}));
            ex_irq = (l <= 6); ex_a = (l <= 4); ex_b = (l <= 2);
            check("R8", "tx irq", 32'(irq_req_t), 32'(ex_irq));
            check("R8", "tx dma a", 32'(dma_a_req_t), 32'(ex_a));
            check("R8", "tx dma b", 32'(dma_b_req_t), 32'(ex_b));
            check("R10", "tx status", 32'(req_status_t), 32'({ex_b, ex_a, ex_irq}));
            if (l < 8) cyc(1, 32'(l), 0, 0);
        end
        // widest 4-bit irq depth is above any level
        irq_depth = 4'hF; #1;
        check("R9", "rx irq at depth 15", 32'(irq_req), 0);
        check("R9", "tx irq at depth 15", 32'(irq_req_t), 1);
        dma_b_depth = 5'd16; #1;
        check("R9", "rx dma b at depth 16", 32'(dma_b_req), 0);
        // enables gate each line
        irq_en = 0; dma_a_en = 0; dma_b_en = 0; #1;
        check("R7", "rx all disabled", 32'(req_status), 0);
        check("R8", "tx all disabled", 32'(req_status_t), 0);
        dma_a_en = 1; dma_a_depth = 5'd0; #1;
        check("R7", "rx dma a alone", 32'(req_status), 32'b010);
        cyc(0, 0, 0, 1);
        check("R8", "tx dma a at depth 0 when empty", 32'(req_status_t), 32'b010);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_order();
        t_overflow();
        t_simultaneous();
        t_clear();
        t_thresholds();
        finish_up();
    end

endmodule